// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator

This block holds one 32-bit breakpoint word that software writes and can read back. On every cycle with a valid instruction fetch, it compares the word address of the fetch with the stored word address. It raises a one-cycle hit pulse when three conditions all hold: the address matches, breakpoint checking is armed, and the stored translation bit equals the processor's current instruction-translation mode. Because of the translation bit, a single breakpoint targets either translated fetches or untranslated fetches, never both.

A small controller with two states tracks whether the breakpoint is armed. `ST_OFF` is the reset state, and in it no hit is produced. `ST_ARMED` allows hits. The controller has two named transitions, both taken on a register write. `T_ARM` moves `ST_OFF` to `ST_ARMED` when the written enable bit is 1. `T_DISARM` moves `ST_ARMED` to `ST_OFF` when the written enable bit is 0. A write that leaves the enable bit unchanged keeps the current state. The hit output is registered, so it appears in the cycle after the qualifying fetch.

Top module: `iabp_top`

## Requirements
- R1: After reset, `cfg_rdata` is all zeros and `bp_hit` is 0, so breakpoints start disabled.
- R2: When `cfg_we` is high at a clock edge, `cfg_rdata` equals `cfg_wdata` from the next cycle on, all 32 bits. Without a write, `cfg_rdata` holds its value.
- R3: Bits [31:2] of the register hold the word address, which is compared with `fetch_addr[31:2]`. The fetch-address bits [1:0] have no effect on a match.
- R4: Bit [1] is the enable bit. While it is 0, `bp_hit` never asserts.
- R5: Bit [0] is the translation bit. A hit requires it to equal `xlate_mode` in the fetch cycle.
- R6: `bp_hit` is high for exactly the one cycle after each qualifying fetch. It does not assert when `fetch_valid` is low, and back-to-back qualifying fetches give back-to-back pulses.
- R7: A fetch in the same cycle as a register write is judged against the old register value. The new value applies from the next fetch on.
- R8: A fetch whose word address differs from the stored one does not produce a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Write data: [31:2] word address, [1] enable, [0] translation |
| cfg_rdata | output | 32 | Register readback |
| fetch_valid | input | 1 | Instruction fetch valid |
| fetch_addr | input | 32 | Fetch byte address |
| xlate_mode | input | 1 | Current instruction-translation mode |
| bp_hit | output | 1 | Registered one-cycle breakpoint hit |

## Verification
The assertions take two things for granted. First, reset is held for at least one clock edge before any check counts. Second, every input is stable around the rising edge. From these they judge each hit against the readback value and the fetch inputs of the previous cycle. The bench drives every input on the falling edge and holds it for a full cycle, so each fetch and write is seen at exactly one rising edge. It also deliberately lines up a write and a fetch in the same cycle, so the ordering in R7 is exercised within these assumptions.

// File: rtl/iabp_pkg.sv
package iabp_pkg;
    localparam int DATA_W   = 32;
    localparam int BYTE_OFS = 2;
    localparam int WORD_W   = DATA_W - BYTE_OFS;

    typedef enum logic [0:0] {
        ST_OFF   = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;
endpackage

// File: rtl/iabp_reg.sv
module iabp_reg #(
    parameter int DW = iabp_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= wdata;
    end
endmodule

// File: rtl/iabp_cmp.sv
module iabp_cmp #(
    parameter int DW  = iabp_pkg::DATA_W,
    parameter int OFS = iabp_pkg::BYTE_OFS
) (
    input  logic [DW-1:0] bp_word,
    input  logic [DW-1:0] fetch_addr,
    input  logic          xlate_mode,
    output logic          addr_eq,
    output logic          mode_ok
);
    localparam int WW = DW - OFS;

    logic [WW-1:0] stored_word;
    logic [WW-1:0] fetch_word;

    assign stored_word = bp_word[DW-1:OFS];
    assign fetch_word  = fetch_addr[DW-1:OFS];
    assign addr_eq     = (stored_word == fetch_word);
    assign mode_ok     = (bp_word[0] == xlate_mode);
endmodule

// File: rtl/iabp_ctrl.sv
module iabp_ctrl
    import iabp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_arm,
    input  logic fetch_valid,
    input  logic addr_eq,
    input  logic mode_ok,
    output logic hit
);
    arm_state_e state_q, state_d;
    logic       hit_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (wr_en && wr_arm)  state_d = ST_ARMED;  // T_ARM
            ST_ARMED: if (wr_en && !wr_arm) state_d = ST_OFF;    // T_DISARM
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        hit_d = 1'b0;
        unique case (state_q)
            ST_OFF:   hit_d = 1'b0;
            ST_ARMED: hit_d = fetch_valid && addr_eq && mode_ok;
            default:  hit_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            hit <= 1'b0;
        else
            hit <= hit_d;
    end
endmodule

// File: rtl/iabp_top.sv
module iabp_top #(
    parameter int DW  = iabp_pkg::DATA_W,
    parameter int OFS = iabp_pkg::BYTE_OFS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          fetch_valid,
    input  logic [DW-1:0] fetch_addr,
    input  logic          xlate_mode,
    output logic          bp_hit
);
    localparam int ARM_BIT = 1;

    logic [DW-1:0] bp_q;
    logic          addr_eq;
    logic          mode_ok;

    iabp_reg #(.DW(DW)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (bp_q)
    );

    iabp_cmp #(.DW(DW), .OFS(OFS)) u_cmp (
        .bp_word    (bp_q),
        .fetch_addr (fetch_addr),
        .xlate_mode (xlate_mode),
        .addr_eq    (addr_eq),
        .mode_ok    (mode_ok)
    );

    iabp_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_arm      (cfg_wdata[ARM_BIT]),
        .fetch_valid (fetch_valid),
        .addr_eq     (addr_eq),
        .mode_ok     (mode_ok),
        .hit         (bp_hit)
    );

    assign cfg_rdata = bp_q;
endmodule

// File: rtl/iabp_chk.sv
module iabp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        fetch_valid,
    input logic [31:0] fetch_addr,
    input logic        xlate_mode,
    input logic        bp_hit
);
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    a_r3_word_match: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |-> ($past(cfg_rdata[31:2]) == $past(fetch_addr[31:2])));

    a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |-> $past(cfg_rdata[1]));

    a_r5_mode_agree: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |-> ($past(cfg_rdata[0]) == $past(xlate_mode)));

    a_r6_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit |-> $past(fetch_valid));
endmodule

bind iabp_top iabp_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .xlate_mode  (xlate_mode),
    .bp_hit      (bp_hit)
);

// File: tb/iabp_top_tb.sv
module iabp_top_tb;
    typedef struct {
        logic        hit;
        logic [31:0] rdata;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        xlate_mode = 1'b0;
    logic        bp_hit;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] model = '0;
    exp_t        sb[$];

    always #10 clk = ~clk;

    iabp_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .xlate_mode(xlate_mode), .bp_hit(bp_hit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
    task automatic step(input logic we, input logic [31:0] wd, input logic fv,
                        input logic [31:0] fa, input logic xm, input string req);
        exp_t e;
        @(negedge clk);
        cfg_we = we; cfg_wdata = wd; fetch_valid = fv; fetch_addr = fa; xlate_mode = xm;
        e.hit = fv && model[1] && (model[0] == xm) && (model[31:2] == fa[31:2]);
        if (we) model = wd;
        e.rdata = model;
        e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " hit"}, {31'd0, bp_hit}, {31'd0, e.hit});
                check({e.req, " rdata"}, cfg_rdata, e.rdata);
            end
        end
    end

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected <5000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset rdata", cfg_rdata, 32'h0);
        check("R1 reset hit", {31'd0, bp_hit}, 32'h0);
        step(0, 0, 1, 32'h0, 0, "R1 disabled after reset");
        step(1, 32'h0000_1002, 0, 0, 0, "R2 write armed te0");
        step(0, 0, 1, 32'h0000_1000, 0, "R6 qualifying fetch");
        step(0, 0, 1, 32'h0000_1003, 0, "R3 low bits ignored");
        step(0, 0, 1, 32'h0000_1004, 0, "R8 next word no hit");
        step(0, 0, 1, 32'h8000_1000, 0, "R8 high bit differs");
        step(0, 0, 1, 32'h0000_1000, 1, "R5 mode mismatch");
        step(0, 0, 0, 32'h0000_1000, 0, "R6 no fetch valid");
        step(1, 32'h0000_1003, 1, 32'h0000_1000, 0, "R7 write same cycle old value");
        step(0, 0, 1, 32'h0000_1000, 0, "R5 te1 vs mode0");
        step(0, 0, 1, 32'h0000_1000, 1, "R5 te1 vs mode1");
        step(1, 32'h0000_1001, 1, 32'h0000_1000, 1, "R7 disarm same cycle");
        step(0, 0, 1, 32'h0000_1000, 1, "R4 disabled no hit");
        step(0, 0, 1, 32'h0000_1001, 1, "R4 disabled again");
        step(1, 32'hFFFF_FFFE, 0, 0, 0, "R2 write top word");
        step(0, 0, 1, 32'hFFFF_FFFC, 0, "R6 back to back one");
        step(0, 0, 1, 32'hFFFF_FFFF, 0, "R6 back to back two");
        step(0, 0, 0, 32'hFFFF_FFFC, 0, "R6 pulse ends");
        step(1, 32'h0000_0000, 0, 0, 0, "R2 clear register");
        step(0, 0, 1, 32'h0000_0000, 0, "R4 zero reg no hit");
        step(0, 0, 0, 0, 0, "R2 hold");
        @(negedge clk);
        cfg_we = 0; fetch_valid = 0;
        repeat (3) @(posedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule